// File: doc/BRIEF.md
# Codec Register Access Engine

This block sits between a host register port and an AC-link frame engine. It carries out one read or one write of a codec register at a time. The host gives a request with a codec class (audio or modem), a codec ID, a 7-bit register index and, for a write, a 16-bit value. The block checks the request against the ID and register windows allowed for its class. A legal request is held as a command until the frame engine takes it at the next frame boundary. A request that breaks the rules ends at once with an error, and no frame carries it.

A write completes when the frame that carried it ends. A read must be answered in the frame straight after the one that carried the command. The answer is taken from the status slots on the addressed codec's input line. If no matching answer appears in that frame, the access ends with a timeout. While an access is pending, a busy semaphore refuses any new request and leaves the pending access untouched.

The frame engine gives one `frame_tick` pulse per frame boundary. In that cycle it latches the command outputs for the frame that is starting. In the same cycle it presents the status slots it received, for each codec line, in the frame that has just ended.

Top module: `creg_access_eng`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `cmd_valid`, `done` and `refused` are low.
- R2: A legal request taken while idle raises `busy` on the next cycle. `cmd_valid` stays high with unchanged slots until the first `frame_tick`, and drops on the cycle after that tick.
- R3: A request made while `busy` is high gives a one-cycle `refused` pulse on the next cycle and does not change the pending command or its result.
- R4: Audio requests may use codec IDs 0, 1 and 2, and modem requests only IDs 0 and 1. Any other ID gives `done` with `done_err`=1 and `done_tmo`=0 on the next cycle, and `cmd_valid` never rises for it.
- R5: Audio requests may use register indices 00h–3Ah or 5Ah–7Eh. Modem requests may use 3Ch–58h or 5Ah–7Eh. An index outside the window is rejected in the same way as in R4.
- R6: `cmd_addr` bit 19 is 1 for a read and 0 for a write, bits 18:12 hold the register index and bits 11:0 are zero. `cmd_data` bits 19:4 hold the write value and bits 3:0 are zero; for a read, `cmd_data` is all zero.
- R7: For codec ID 0, `tag_slot_vld[1]` (command address slot valid) is 1, `tag_slot_vld[0]` (command data slot valid) is 1 only for a write, and `tag_cid` is 0. For any other ID, `tag_slot_vld` is 0 and `tag_cid` carries the ID.
- R8: A write completes with `done`=1 and `done_err`=0 on the cycle after the second `frame_tick` counted from the one that issued it.
- R9: A read completes on the cycle after the second `frame_tick` following issue. It succeeds only if, at that tick, the addressed codec's line has its valid bit set and status address bits 18:12 equal the index. `done_rdata` is then that line's status data bits 19:4. Status seen at the first tick is ignored.
- R10: A read without a matching answer at that tick ends with `done_err`=1, `done_tmo`=1 and `done_rdata`=0.
- R11: `done` is a one-cycle pulse per access, and `busy` is already low in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_modem | input | 1 | 1 = modem codec class, 0 = audio |
| req_cid | input | 2 | Target codec ID |
| req_idx | input | 7 | Register index |
| req_wdata | input | 16 | Write value |
| frame_tick | input | 1 | Frame boundary pulse from the frame engine |
| rx_addr | input | 60 | Received status address slot, 20 bits per codec line |
| rx_data | input | 60 | Received status data slot, 20 bits per codec line |
| rx_vld | input | 3 | Status slots valid, one bit per codec line |
| busy | output | 1 | Access semaphore |
| refused | output | 1 | Request refused because busy |
| cmd_valid | output | 1 | Command waiting for the next frame |
| cmd_addr | output | 20 | Outgoing command address slot |
| cmd_data | output | 20 | Outgoing command data slot |
| tag_slot_vld | output | 2 | Tag valid bits for command address/data slots |
| tag_cid | output | 2 | Tag codec ID field |
| done | output | 1 | Access complete pulse |
| done_err | output | 1 | Access ended in error |
| done_tmo | output | 1 | Error was a read timeout |
| done_rdata | output | 16 | Read result |

## Verification
A table of accesses covers both classes, every codec ID and the edges of each register window, including the gaps between them. Legal requests are told apart from rejected ones by whether a command appears. On every read, a decoy answer with the right index sits on the codec line during the frame that carried the command. Three failing answers are also used: no answer, an answer with the wrong index, and an answer on a different codec's line. These separate a design that checks the right frame, index and line from one that accepts anything valid. Directed tests cover refusal during a pending access, varied delays before the frame tick, and reset in the middle of an access.

// File: rtl/creg_pkg.sv
package creg_pkg;
  localparam int CID_W  = 2;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 16;
  localparam int SLOT_W = 20;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_SENT = 2'd2,
    ST_RDWT = 2'd3
  } creg_state_e;

  typedef struct packed {
    logic              wr;
    logic [CID_W-1:0]  cid;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wdata;
  } creg_req_t;
endpackage

// File: rtl/creg_req_check.sv
module creg_req_check
  import creg_pkg::*;
#(
  parameter logic [IDX_W-1:0] AUD_END     = 7'h3A,
  parameter logic [IDX_W-1:0] MDM_LO      = 7'h3C,
  parameter logic [IDX_W-1:0] MDM_HI      = 7'h58,
  parameter logic [IDX_W-1:0] VND_LO      = 7'h5A,
  parameter logic [IDX_W-1:0] VND_HI      = 7'h7E,
  parameter int               AUD_MAX_CID = 2,
  parameter int               MDM_MAX_CID = 1
) (
  input  logic             is_modem,
  input  logic [CID_W-1:0] cid,
  input  logic [IDX_W-1:0] idx,
  output logic             legal
);
  localparam logic [CID_W-1:0] AUD_CID_LIM = CID_W'(AUD_MAX_CID);
  localparam logic [CID_W-1:0] MDM_CID_LIM = CID_W'(MDM_MAX_CID);

  logic in_vendor;
  logic in_audio;
  logic in_modem;
  logic cid_ok;

  always_comb begin
    in_vendor = (idx >= VND_LO) && (idx <= VND_HI);
    in_audio  = (idx <= AUD_END) || in_vendor;
    in_modem  = ((idx >= MDM_LO) && (idx <= MDM_HI)) || in_vendor;
    cid_ok    = is_modem ? (cid <= MDM_CID_LIM) : (cid <= AUD_CID_LIM);
    legal     = cid_ok && (is_modem ? in_modem : in_audio);
  end
endmodule

// File: rtl/creg_slot_fmt.sv
module creg_slot_fmt
  import creg_pkg::*;
(
  input  creg_req_t         cur,
  output logic [SLOT_W-1:0] addr_slot,
  output logic [SLOT_W-1:0] data_slot,
  output logic [1:0]        tag_vld,
  output logic [CID_W-1:0]  tag_id
);
  localparam int ADDR_PAD = SLOT_W - 1 - IDX_W;
  localparam int DATA_PAD = SLOT_W - DATA_W;

  always_comb begin
    addr_slot = {~cur.wr, cur.idx, {ADDR_PAD{1'b0}}};
    data_slot = cur.wr ? {cur.wdata, {DATA_PAD{1'b0}}} : '0;
    if (cur.cid == '0) begin
      tag_vld = {1'b1, cur.wr};
      tag_id  = '0;
    end else begin
      tag_vld = 2'b00;
      tag_id  = cur.cid;
    end
  end
endmodule

// File: rtl/creg_rx_pick.sv
module creg_rx_pick
  import creg_pkg::*;
#(
  parameter int NCODEC = 3
) (
  input  logic [CID_W-1:0]         cid,
  input  logic [IDX_W-1:0]         idx,
  input  logic [NCODEC*SLOT_W-1:0] rx_addr,
  input  logic [NCODEC*SLOT_W-1:0] rx_data,
  input  logic [NCODEC-1:0]        rx_vld,
  output logic                     hit,
  output logic [DATA_W-1:0]        rdata
);
  localparam int IDX_LSB = SLOT_W - 1 - IDX_W;
  localparam int DAT_LSB = SLOT_W - DATA_W;

  logic [NCODEC-1:0] match;
  logic [DATA_W-1:0] part [NCODEC];

  for (genvar g = 0; g < NCODEC; g++) begin : g_line
    logic [SLOT_W-1:0] a_s;
    logic [SLOT_W-1:0] d_s;
    logic              unused_line;
    assign a_s = rx_addr[g*SLOT_W +: SLOT_W];
    assign d_s = rx_data[g*SLOT_W +: SLOT_W];
    assign match[g] = rx_vld[g] && (cid == CID_W'(g)) &&
                      (a_s[SLOT_W-2 -: IDX_W] == idx);
    assign part[g] = match[g] ? d_s[SLOT_W-1 -: DATA_W] : '0;
    assign unused_line = ^{a_s[SLOT_W-1], a_s[IDX_LSB-1:0], d_s[DAT_LSB-1:0]};
  end

  always_comb begin
    hit   = |match;
    rdata = '0;
    for (int k = 0; k < NCODEC; k++) rdata = rdata | part[k];
  end
endmodule

// File: rtl/creg_seq.sv
module creg_seq
  import creg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  creg_req_t         req_in,
  input  logic              req_legal,
  input  logic              frame_tick,
  input  logic              rx_hit,
  input  logic [DATA_W-1:0] rx_rdata,
  output creg_req_t         cur,
  output logic              busy,
  output logic              cmd_valid,
  output logic              refused,
  output logic              done,
  output logic              done_err,
  output logic              done_tmo,
  output logic [DATA_W-1:0] done_rdata
);
  creg_state_e       st_q, st_n;
  creg_req_t         cur_q;
  logic              cur_en;
  logic              refused_q, refused_n;
  logic              done_q, done_n;
  logic              err_q, err_n;
  logic              tmo_q, tmo_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;

  always_comb begin
    st_n      = st_q;
    cur_en    = 1'b0;
    done_n    = 1'b0;
    err_n     = 1'b0;
    tmo_n     = 1'b0;
    rdata_n   = '0;
    refused_n = req_valid && (st_q != ST_IDLE);
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_legal) begin
            st_n   = ST_PEND;
            cur_en = 1'b1;
          end else begin
            done_n = 1'b1;
            err_n  = 1'b1;
          end
        end
      end
      ST_PEND: begin
        if (frame_tick) st_n = ST_SENT;
      end
      ST_SENT: begin
        if (frame_tick) begin
          if (cur_q.wr) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else begin
            st_n = ST_RDWT;
          end
        end
      end
      ST_RDWT: begin
        if (frame_tick) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
          if (rx_hit) begin
            rdata_n = rx_rdata;
          end else begin
            err_n = 1'b1;
            tmo_n = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      refused_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      tmo_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      st_q      <= st_n;
      refused_q <= refused_n;
      done_q    <= done_n;
      err_q     <= err_n;
      tmo_q     <= tmo_n;
      rdata_q   <= rdata_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (cur_en) begin
      cur_q <= req_in;
    end
  end

  assign cur        = cur_q;
  assign busy       = (st_q != ST_IDLE);
  assign cmd_valid  = (st_q == ST_PEND);
  assign refused    = refused_q;
  assign done       = done_q;
  assign done_err   = err_q;
  assign done_tmo   = tmo_q;
  assign done_rdata = rdata_q;
endmodule

// File: rtl/creg_access_eng.sv
module creg_access_eng
  import creg_pkg::*;
#(
  parameter int NCODEC = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_modem,
  input  logic [CID_W-1:0]         req_cid,
  input  logic [IDX_W-1:0]         req_idx,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     frame_tick,
  input  logic [NCODEC*SLOT_W-1:0] rx_addr,
  input  logic [NCODEC*SLOT_W-1:0] rx_data,
  input  logic [NCODEC-1:0]        rx_vld,
  output logic                     busy,
  output logic                     refused,
  output logic                     cmd_valid,
  output logic [SLOT_W-1:0]        cmd_addr,
  output logic [SLOT_W-1:0]        cmd_data,
  output logic [1:0]               tag_slot_vld,
  output logic [CID_W-1:0]         tag_cid,
  output logic                     done,
  output logic                     done_err,
  output logic                     done_tmo,
  output logic [DATA_W-1:0]        done_rdata
);
  creg_req_t         req_in;
  creg_req_t         cur;
  logic              legal;
  logic              rx_hit;
  logic [DATA_W-1:0] rx_rdata;

  assign req_in = '{wr: req_write, cid: req_cid, idx: req_idx, wdata: req_wdata};

  creg_req_check u_check (
    .is_modem (req_modem),
    .cid      (req_cid),
    .idx      (req_idx),
    .legal    (legal)
  );

  creg_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_in     (req_in),
    .req_legal  (legal),
    .frame_tick (frame_tick),
    .rx_hit     (rx_hit),
    .rx_rdata   (rx_rdata),
    .cur        (cur),
    .busy       (busy),
    .cmd_valid  (cmd_valid),
    .refused    (refused),
    .done       (done),
    .done_err   (done_err),
    .done_tmo   (done_tmo),
    .done_rdata (done_rdata)
  );

  creg_slot_fmt u_fmt (
    .cur       (cur),
    .addr_slot (cmd_addr),
    .data_slot (cmd_data),
    .tag_vld   (tag_slot_vld),
    .tag_id    (tag_cid)
  );

  creg_rx_pick #(.NCODEC(NCODEC)) u_pick (
    .cid     (cur.cid),
    .idx     (cur.idx),
    .rx_addr (rx_addr),
    .rx_data (rx_data),
    .rx_vld  (rx_vld),
    .hit     (rx_hit),
    .rdata   (rx_rdata)
  );
endmodule

// File: rtl/creg_access_chk.sv
module creg_access_chk
  import creg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              busy,
  input logic              refused,
  input logic              cmd_valid,
  input logic [SLOT_W-1:0] cmd_addr,
  input logic [SLOT_W-1:0] cmd_data,
  input logic [1:0]        tag_slot_vld,
  input logic [CID_W-1:0]  tag_cid,
  input logic              done,
  input logic              done_err,
  input logic              done_tmo,
  input logic [DATA_W-1:0] done_rdata
);
  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  refuse_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> $past(busy));

  // R2
  cmd_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !frame_tick) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));

  // R6
  read_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr[SLOT_W-1]) |-> (cmd_data == '0));

  // R7
  tag_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && tag_cid != '0) |-> (tag_slot_vld == 2'b00));

  // R7
  tag_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && tag_cid == '0) |-> (tag_slot_vld[1] && (tag_slot_vld[0] == !cmd_addr[SLOT_W-1])));

  // R10
  tmo_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_tmo) |-> (done_err && done_rdata == '0));

  // R8
  ok_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> $past(frame_tick));
endmodule

bind creg_access_eng creg_access_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_tick   (frame_tick),
  .busy         (busy),
  .refused      (refused),
  .cmd_valid    (cmd_valid),
  .cmd_addr     (cmd_addr),
  .cmd_data     (cmd_data),
  .tag_slot_vld (tag_slot_vld),
  .tag_cid      (tag_cid),
  .done         (done),
  .done_err     (done_err),
  .done_tmo     (done_tmo),
  .done_rdata   (done_rdata)
);

// File: tb/sim_creg_access_eng.sv
`timescale 1ns/1ps
module sim_creg_access_eng;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, req_modem;
  logic [1:0]  req_cid;
  logic [6:0]  req_idx;
  logic [15:0] req_wdata;
  logic        frame_tick;
  logic [59:0] rx_addr, rx_data;
  logic [2:0]  rx_vld;
  logic        busy, refused, cmd_valid, done, done_err, done_tmo;
  logic [19:0] cmd_addr, cmd_data;
  logic [1:0]  tag_slot_vld, tag_cid;
  logic [15:0] done_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  creg_access_eng u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_modem(req_modem), .req_cid(req_cid), .req_idx(req_idx), .req_wdata(req_wdata),
    .frame_tick(frame_tick), .rx_addr(rx_addr), .rx_data(rx_data), .rx_vld(rx_vld),
    .busy(busy), .refused(refused), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .tag_slot_vld(tag_slot_vld), .tag_cid(tag_cid), .done(done),
    .done_err(done_err), .done_tmo(done_tmo), .done_rdata(done_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // wr, modem, cid, idx, wdata, resp(0 none,1 ok,2 wrong idx,3 other line), rdat, exp_rej, exp_tmo, delay
  localparam logic [48:0] VEC [16] = '{
    {1'b1,1'b0,2'd0,7'h02,16'hA5A5,2'd0,16'h0000,1'b0,1'b0,2'd0},
    {1'b0,1'b0,2'd1,7'h3A,16'h0000,2'd1,16'h1234,1'b0,1'b0,2'd1},
    {1'b0,1'b0,2'd2,7'h7E,16'h0000,2'd1,16'hBEEF,1'b0,1'b0,2'd2},
    {1'b1,1'b0,2'd2,7'h5A,16'h5A5A,2'd0,16'h0000,1'b0,1'b0,2'd0},
    {1'b0,1'b0,2'd0,7'h3C,16'h0000,2'd0,16'h0000,1'b1,1'b0,2'd0},
    {1'b1,1'b0,2'd3,7'h10,16'h0000,2'd0,16'h0000,1'b1,1'b0,2'd0},
    {1'b1,1'b1,2'd1,7'h3C,16'hC3C3,2'd0,16'h0000,1'b0,1'b0,2'd1},
    {1'b0,1'b1,2'd0,7'h58,16'h0000,2'd1,16'h0F0F,1'b0,1'b0,2'd0},
    {1'b0,1'b1,2'd2,7'h40,16'h0000,2'd0,16'h0000,1'b1,1'b0,2'd0},
    {1'b1,1'b1,2'd0,7'h3A,16'h0000,2'd0,16'h0000,1'b1,1'b0,2'd0},
    {1'b0,1'b0,2'd1,7'h10,16'h0000,2'd0,16'h0000,1'b0,1'b1,2'd0},
    {1'b0,1'b0,2'd0,7'h20,16'h0000,2'd2,16'h4321,1'b0,1'b1,2'd1},
    {1'b0,1'b1,2'd1,7'h5A,16'h0000,2'd3,16'h7777,1'b0,1'b1,2'd0},
    {1'b1,1'b1,2'd0,7'h7E,16'h0001,2'd0,16'h0000,1'b0,1'b0,2'd2},
    {1'b1,1'b0,2'd0,7'h7F,16'h0000,2'd0,16'h0000,1'b1,1'b0,2'd0},
    {1'b0,1'b0,2'd0,7'h00,16'h0000,2'd1,16'hFFFF,1'b0,1'b0,2'd0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_rx();
    rx_addr = '0;
    rx_data = '0;
    rx_vld  = '0;
  endtask

  task automatic set_rx(input int c, input logic [6:0] ix, input logic [15:0] d);
    rx_addr[c*20 +: 20] = {1'b0, ix, 12'h000};
    rx_data[c*20 +: 20] = {d, 4'h0};
    rx_vld[c] = 1'b1;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    step();
    frame_tick = 1'b0;
  endtask

  task automatic request(input logic wr, input logic mdm, input logic [1:0] cid,
                         input logic [6:0] ix, input logic [15:0] wd);
    req_valid = 1'b1; req_write = wr; req_modem = mdm;
    req_cid = cid; req_idx = ix; req_wdata = wd;
    step();
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_modem = 1'b0;
    req_cid = '0; req_idx = '0; req_wdata = '0; frame_tick = 1'b0;
    clear_rx();
    #1;
    // R1 during reset
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "cmd_valid in reset", cmd_valid, 0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1", "done after reset", done, 0);
    chk("R1", "refused after reset", refused, 0);
    chk("R1", "busy after reset", busy, 0);

    for (int i = 0; i < 16; i++) begin
      logic [48:0] v;
      logic wr, mdm, rej, tmo;
      logic [1:0] cid, resp, dly;
      logic [6:0] ix;
      logic [15:0] wd, rd;
      v = VEC[i];
      wr = v[48]; mdm = v[47]; cid = v[46:45]; ix = v[44:38]; wd = v[37:22];
      resp = v[21:20]; rd = v[19:4]; rej = v[3]; tmo = v[2]; dly = v[1:0];
      clear_rx();
      request(wr, mdm, cid, ix, wd);
      if (rej) begin
        chk("R4/R5", "reject done", done, 1);
        chk("R4/R5", "reject err", done_err, 1);
        chk("R4/R5", "reject tmo", done_tmo, 0);
        chk("R4/R5", "reject no cmd", cmd_valid, 0);
        chk("R4/R5", "reject not busy", busy, 0);
        step();
        chk("R11", "reject done pulse", done, 0);
      end else begin
        chk("R2", "busy after accept", busy, 1);
        chk("R2", "cmd_valid", cmd_valid, 1);
        chk("R6", "cmd_addr", cmd_addr, {~wr, ix, 12'h000});
        chk("R6", "cmd_data", cmd_data, wr ? {wd, 4'h0} : 20'h0);
        chk("R7", "tag_slot_vld", tag_slot_vld, (cid == 2'd0) ? {1'b1, wr} : 2'b00);
        chk("R7", "tag_cid", tag_cid, cid);
        for (int d = 0; d < int'(dly); d++) step();
        chk("R2", "cmd held until tick", cmd_valid, 1);
        tick();
        chk("R2", "cmd dropped after tick", cmd_valid, 0);
        chk("R2", "busy after issue", busy, 1);
        if (wr) begin
          tick();
          chk("R8", "write done", done, 1);
          chk("R8", "write err", done_err, 0);
          chk("R11", "busy low with done", busy, 0);
        end else begin
          set_rx(int'(cid), ix, ~rd);
          tick();
          clear_rx();
          chk("R9", "no done at first tick", done, 0);
          case (resp)
            2'd1: set_rx(int'(cid), ix, rd);
            2'd2: set_rx(int'(cid), ix ^ 7'h02, rd);
            2'd3: set_rx((int'(cid) + 1) % 3, ix, rd);
            default: ;
          endcase
          tick();
          clear_rx();
          chk("R9", "read done", done, 1);
          chk("R10", "read err", done_err, tmo);
          chk("R10", "read tmo", done_tmo, tmo);
          chk("R9", "read data", done_rdata, tmo ? 16'h0 : rd);
          chk("R11", "busy low with done", busy, 0);
        end
        step();
        chk("R11", "done one cycle", done, 0);
      end
    end

    // R3: refusal while pending leaves the pending write intact
    request(1'b1, 1'b0, 2'd1, 7'h04, 16'h1111);
    chk("R3", "no refusal on accept", refused, 0);
    request(1'b0, 1'b0, 2'd0, 7'h06, 16'h0000);
    chk("R3", "refused pulse", refused, 1);
    chk("R3", "pending addr kept", cmd_addr, {1'b0, 7'h04, 12'h000});
    chk("R3", "pending data kept", cmd_data, {16'h1111, 4'h0});
    step();
    chk("R3", "refused one cycle", refused, 0);
    tick();
    request(1'b1, 1'b1, 2'd0, 7'h40, 16'h2222);
    chk("R3", "refused while sent", refused, 1);
    tick();
    chk("R3", "pending write finishes", done, 1);
    chk("R3", "pending write no err", done_err, 0);

    // R1: reset in the middle of an access
    step();
    request(1'b0, 1'b0, 2'd2, 7'h08, 16'h0000);
    tick();
    rst_n = 1'b0;
    #1;
    chk("R1", "busy cleared by reset", busy, 0);
    chk("R1", "cmd cleared by reset", cmd_valid, 0);
    step();
    rst_n = 1'b1;
    step();
    chk("R1", "idle after reset", busy, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule